// File: doc/BRIEF.md
# Maskable Interrupt Controller with Normal/Fast Routing

This block collects a word of interrupt request lines and turns them into two processor requests: a normal interrupt and a fast interrupt. Each line has an enable bit and a routing bit. An enabled line that is high is pending. A pending line then drives the normal output or the fast output, depending on its routing bit. The low lines come from the GPIO unit: lines 0 to 7 are single GPIO pins and line 8 is the summary of the upper GPIO pins. The remaining lines come from internal peripherals. Every line is level-sensitive, so a line stays pending only while its input stays high, and there is nothing to acknowledge.

Software programs the block through a small word-addressed register port. A global enable bit gates both processor outputs. A read-only index register gives the lowest-numbered pending source on the normal path, so a handler can dispatch without scanning the word. A separate wake output tells the power manager that an armed source is high. Only the nine GPIO lines and the alarm line can be armed to wake the system.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, routing, wake-arm and control registers read zero, and `irq_o`, `fiq_o` and `wake_o` are low.
- R2: The pending register (address 4) reads `src_i & enable_mask` as sampled at the previous clock edge. A disabled source never appears in it.
- R3: `irq_o` rises one clock after an enabled source with routing bit 0 goes high, provided the control enable is set.
- R4: `fiq_o` rises one clock after an enabled source with routing bit 1 goes high, provided the control enable is set. Such a source does not drive `irq_o`.
- R5: Bit 0 of the control register (address 3) gates both processor outputs. While it is 0, `irq_o` and `fiq_o` stay low, but the pending register still updates. The control register reads back only bit 0.
- R6: The index register (address 7) holds a valid flag in bit 31 and, in bits 4:0, the number of the lowest-numbered pending source routed normal. Fast-routed sources are never reported. With nothing normal pending, the register reads zero.
- R7: `wake_o` is high one clock after any source is high with its wake arm set, but only while the controller is disabled or `sleep_i` is high. The enable mask has no effect on it.
- R8: Wake-arm register (address 2) bits 0 to 8 arm sources 0 to 8, and bit 9 arms the alarm source (30 by default). No other source can raise `wake_o`, and bits above 9 read zero.
- R9: Sources are level-sensitive. A pending source clears one clock after its input falls, with no register write. Writes to the read-only addresses 4 to 7 have no effect.
- R10: Address 0 is the enable mask (1 enables a source) and address 1 is the routing word (1 selects fast). Both read back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt request lines, level-sensitive |
| sleep_i | input | 1 | System is in a low-power state |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wakeup request to power management |

## Verification
The bench routes sources both ways at once. A design that ORs the wrong polarity of the routing word would raise the wrong processor line. The index test mixes fast-routed low sources with normal high ones and includes source 31 alone. An encoder that picks the highest bit, ignores routing, or truncates the index would report the wrong number. The wake tests arm only the alarm, then arm every bit while a non-wake source is high, and then enable the controller with and without sleep. These catch a wake path that follows the mask, leaks other sources, or ignores the enable/sleep qualifier. A design that latched sources instead of following their level would keep `irq_o` high after its input falls.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK  = 3'd0,
        RA_ROUTE = 3'd1,
        RA_WAKE  = 3'd2,
        RA_CTRL  = 3'd3,
        RA_PEND  = 3'd4,
        RA_NORM  = 3'd5,
        RA_FAST  = 3'd6,
        RA_INDEX = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC      = 32,
    parameter int unsigned GPIO_SRC  = 9,
    parameter int unsigned ALARM_SRC = 30,
    localparam int unsigned WAKE_W   = GPIO_SRC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    output logic [NSRC-1:0]   mask_o,
    output logic [NSRC-1:0]   route_o,
    output logic [WAKE_W-1:0] wake_arm_o,
    output logic [NSRC-1:0]   wake_vec_o,
    output logic              en_o
);

    typedef struct packed {
        logic [NSRC-1:0]   mask;
        logic [NSRC-1:0]   route;
        logic [WAKE_W-1:0] wake;
        logic              en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            unique case (reg_addr_e'(addr_i))
                RA_MASK:  r_d.mask  = wdata_i;
                RA_ROUTE: r_d.route = wdata_i;
                RA_WAKE:  r_d.wake  = wdata_i[WAKE_W-1:0];
                RA_CTRL:  r_d.en    = wdata_i[0];
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mask_o     = r_q.mask;
    assign route_o    = r_q.route;
    assign wake_arm_o = r_q.wake;
    assign en_o       = r_q.en;

    // Spread the arm bits over the source positions they serve
    for (genvar i = 0; i < NSRC; i++) begin : g_wake
        if (i < GPIO_SRC) begin : g_gpio
            assign wake_vec_o[i] = r_q.wake[i];
        end else if (i == ALARM_SRC) begin : g_alarm
            assign wake_vec_o[i] = r_q.wake[GPIO_SRC];
        end else begin : g_none
            assign wake_vec_o[i] = 1'b0;
        end
    end

    // R9: a write to a read-only address leaves every register unchanged
    p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i[ADDR_W-1]) |=> $stable(r_q));

endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int unsigned NSRC = 32
) (
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic [NSRC-1:0] route_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] norm_o,
    output logic [NSRC-1:0] fast_o
);

    always_comb begin
        pend_o = src_i & mask_i;
        norm_o = pend_o & ~route_i;
        fast_o = pend_o & route_i;
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned N    = 32,
    localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    vec_i,
    output logic [IDXW-1:0] idx_o,
    output logic            valid_o
);

    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o   = IDXW'(i);
                valid_o = 1'b1;
            end
        end
    end

    // R6: a reported index points at a set bit, and no lower bit is set
    always_comb begin
        if (valid_o) begin
            a_idx_hit_r6: assert (vec_i[idx_o]);
            a_idx_low_r6: assert ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0);
        end else begin
            a_idx_none_r6: assert (vec_i == '0);
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC      = 32,
    parameter int unsigned GPIO_SRC  = 9,
    parameter int unsigned ALARM_SRC = 30,
    localparam int unsigned WAKE_W   = GPIO_SRC + 1,
    localparam int unsigned IDXW     = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              sleep_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    output logic [NSRC-1:0]   rdata_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);

    logic [NSRC-1:0]   mask, route, wake_vec;
    logic [WAKE_W-1:0] wake_arm;
    logic              en;
    logic [NSRC-1:0]   pend_c, norm_c, fast_c;
    logic [IDXW-1:0]   idx;
    logic              idx_valid;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] norm;
        logic [NSRC-1:0] fast;
        logic            irq;
        logic            fiq;
        logic            wake;
    } out_t;

    out_t o_d, o_q;

    irqc_regs #(
        .NSRC      (NSRC),
        .GPIO_SRC  (GPIO_SRC),
        .ALARM_SRC (ALARM_SRC)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .mask_o     (mask),
        .route_o    (route),
        .wake_arm_o (wake_arm),
        .wake_vec_o (wake_vec),
        .en_o       (en)
    );

    irqc_route #(.NSRC(NSRC)) i_route (
        .src_i   (src_i),
        .mask_i  (mask),
        .route_i (route),
        .pend_o  (pend_c),
        .norm_o  (norm_c),
        .fast_o  (fast_c)
    );

    irqc_prio #(.N(NSRC)) i_prio (
        .vec_i   (o_q.norm),
        .idx_o   (idx),
        .valid_o (idx_valid)
    );

    always_comb begin
        o_d      = o_q;
        o_d.pend = pend_c;
        o_d.norm = norm_c;
        o_d.fast = fast_c;
        o_d.irq  = en && (|norm_c);
        o_d.fiq  = en && (|fast_c);
        o_d.wake = (!en || sleep_i) && (|(src_i & wake_vec));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (reg_addr_e'(addr_i))
            RA_MASK:  rdata_o = mask;
            RA_ROUTE: rdata_o = route;
            RA_WAKE:  rdata_o = NSRC'(wake_arm);
            RA_CTRL:  rdata_o = NSRC'(en);
            RA_PEND:  rdata_o = o_q.pend;
            RA_NORM:  rdata_o = o_q.norm;
            RA_FAST:  rdata_o = o_q.fast;
            RA_INDEX: begin
                rdata_o[NSRC-1]   = idx_valid;
                rdata_o[IDXW-1:0] = idx;
            end
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o  = o_q.irq;
    assign fiq_o  = o_q.fiq;
    assign wake_o = o_q.wake;

    // R5: a disabled controller requests nothing on the next cycle
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!irq_o && !fiq_o));

    // R2: pending never holds a source that was masked at the sampling edge
    p_pend_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en || !en) |=> ((o_q.pend & ~$past(mask)) == '0));

    // R4: the fast request follows an enabled, fast-routed, high source
    p_fiq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_i & mask & route)) |=> !fiq_o);

    // R3: the normal request follows an enabled, normal-routed, high source
    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_i & mask & ~route)) |=> !irq_o);

    // R7: running and awake means no wake request
    p_wake_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sleep_i) |=> !wake_o);

endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sleep = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irqc_top i_irqc_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .sleep_i (sleep),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq),
        .fiq_o   (fiq),
        .wake_o  (wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic drive(input logic [31:0] s);
        @(negedge clk);
        src = s;
        step();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 mask", v, 32'h0);
        rd(3'd1, v); check("R1 route", v, 32'h0);
        rd(3'd2, v); check("R1 wake", v, 32'h0);
        rd(3'd3, v); check("R1 ctrl", v, 32'h0);
        check("R1 outputs", {29'h0, irq, fiq, wake}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, v); check("R10 mask rb", v, 32'hA5A5_0F0F);
        wr(3'd1, 32'h1234_5678); rd(3'd1, v); check("R10 route rb", v, 32'h1234_5678);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R8 wake rb", v, 32'h0000_03FF);
        wr(3'd3, 32'hFFFF_FFFE); rd(3'd3, v); check("R5 ctrl bit0", v, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R5 ctrl rb", v, 32'h1);
        drive(32'h0000_0F00);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R9 pend ro", v, 32'h0000_0F00 & 32'hA5A5_0F0F);
        wr(3'd7, 32'h0);
        rd(3'd0, v); check("R9 ro keeps mask", v, 32'hA5A5_0F0F);
        drive(32'h0);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(3'd3, 32'h1);
        wr(3'd0, 32'h0000_FF00);
        wr(3'd1, 32'h0000_F000);
        drive(32'h0000_0100);
        check("R3 irq normal", {30'h0, irq, fiq}, 32'h2);
        rd(3'd4, v); check("R2 pend", v, 32'h0000_0100);
        drive(32'h0000_2000);
        check("R4 fiq fast", {30'h0, irq, fiq}, 32'h1);
        rd(3'd6, v); check("R4 fast word", v, 32'h0000_2000);
        drive(32'h0001_0000);
        check("R2 masked quiet", {30'h0, irq, fiq}, 32'h0);
        rd(3'd4, v); check("R2 masked pend", v, 32'h0);
        drive(32'h0000_2100);
        check("R3 R4 both", {30'h0, irq, fiq}, 32'h3);
        drive(32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(3'd3, 32'h0);
        drive(32'h0000_2100);
        check("R5 gated", {30'h0, irq, fiq}, 32'h0);
        rd(3'd4, v); check("R5 pend live", v, 32'h0000_2100);
        drive(32'h0);
    endtask

    task automatic t_index();
        logic [31:0] v;
        wr(3'd3, 32'h1);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_0003);
        drive(32'h8000_0013);
        rd(3'd7, v); check("R6 lowest normal", v, 32'h8000_0004);
        drive(32'h0000_0003);
        rd(3'd7, v); check("R6 fast excluded", v, 32'h0);
        check("R6 fiq only", {30'h0, irq, fiq}, 32'h1);
        drive(32'h8000_0000);
        rd(3'd7, v); check("R6 top source", v, 32'h8000_001F);
        drive(32'h0);
        rd(3'd7, v); check("R6 empty", v, 32'h0);
    endtask

    task automatic t_level();
        drive(32'h0000_0400);
        check("R9 held c1", {31'h0, irq}, 32'h1);
        step();
        check("R9 held c2", {31'h0, irq}, 32'h1);
        drive(32'h0);
        check("R9 drops", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_wake();
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0000_0200);
        drive(32'h4000_0000);
        check("R8 alarm wake", {31'h0, wake}, 32'h1);
        drive(32'h0000_0001);
        check("R8 unarmed", {31'h0, wake}, 32'h0);
        wr(3'd2, 32'h0000_03FF);
        drive(32'h2000_0200);
        check("R8 others never", {31'h0, wake}, 32'h0);
        drive(32'h0000_0100);
        check("R8 summary wake", {31'h0, wake}, 32'h1);
        wr(3'd3, 32'h1);
        step();
        check("R7 running", {31'h0, wake}, 32'h0);
        @(negedge clk);
        sleep = 1'b1;
        step();
        check("R7 sleeping", {31'h0, wake}, 32'h1);
        @(negedge clk);
        sleep = 1'b0;
        src = '0;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_route();
        t_enable();
        t_index();
        t_level();
        t_wake();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule